// File: doc/BRIEF.md
# Dual-Tap Camera Video Timing Generator

This block produces the framing signals and two parallel pixel taps of a camera's output, one step per pixel clock. A single request starts a frame. The block first raises frame valid. After a fixed lead-in it runs a set number of lines. Each line keeps line valid high for a set number of cycles and sends two 8-bit pixels per cycle. A fixed low gap on line valid separates one line from the next. Once the last line is done, frame valid drops and a frame blanking interval follows before the block will accept another request.

Pixel pairs come from an upstream source through a ready/valid handshake. Ready is high only while line valid is high, and each accepted pair goes straight to the taps in the same cycle. If the source has no pair ready during an active cycle, the taps output zero for that cycle and a sticky underrun flag is set. The flag is cleared when the next frame starts. Line count, active cycles per line, inter-line gap, lead-in and frame blanking are all parameters.

Top module: `dual_tap_vid_gen`

## Requirements
- R1: After reset, and while idle with no request, `fval`, `lval`, `src_ready`, `tap0`, `tap1` and `underrun` are all 0.
- R2: If `sof_req` is high in an idle cycle, `fval` is 1 from the next cycle on. `lval` first goes high exactly FV_LEAD (default 5) cycles after `fval` rises.
- R3: Each line keeps `lval` high for exactly PIX_CYC (default 640) consecutive cycles. `src_ready` equals `lval` in every cycle.
- R4: Between two lines of the same frame, `lval` stays low for exactly LINE_GAP (default 20) cycles and `fval` stays high.
- R5: After LINES lines, `fval` goes low in the cycle right after the last `lval`-high cycle. `lval` is never high while `fval` is low.
- R6: Once `fval` falls, it stays low for FRAME_GAP (default 8) cycles. A `sof_req` seen during a frame or during its blanking has no effect. A request held high starts the next frame one cycle after the blanking ends.
- R7: In a cycle where `lval` and `src_valid` are both high, `tap0` equals `src_pix0` in that same cycle and `tap1` equals `src_pix1`. `src_pix0` carries the odd-numbered pixel of the line (1st, 3rd, ...) and `src_pix1` carries the even-numbered pixel that follows it. Each tap is 8 bits.
- R8: `tap0` and `tap1` are 0 in every cycle where `lval` is low, whatever the source presents.
- R9: In a cycle where `lval` is high and `src_valid` is low, both taps are 0. `underrun` goes high the next cycle and stays high until the cycle in which the next frame's `fval` rises, where it reads 0.
- R10: A synchronous active-high `rst` asserted mid-frame returns the block to idle: all outputs are 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_req | input | 1 | Start-of-frame request, taken only while idle |
| src_valid | input | 1 | Source has a pixel pair ready |
| src_pix0 | input | PIX_W | Odd-numbered pixel of the pair |
| src_pix1 | input | PIX_W | Even-numbered pixel of the pair |
| src_ready | output | 1 | Pair is taken this cycle (high exactly when line valid is high) |
| fval | output | 1 | Frame valid |
| lval | output | 1 | Line valid |
| tap0 | output | PIX_W | First pixel tap |
| tap1 | output | PIX_W | Second pixel tap |
| underrun | output | 1 | Sticky flag: source missed an active cycle |

## Verification
A frame with a single start pulse and a continuous source checks every cycle of the framing against an independent offset model. It separates a lead-in that is one cycle off, a line that is one cycle too long or short, and a gap of the wrong length. The pixel values are a ramp that depends on both line and column, so swapped taps, a column lag or a stale line show up. The source keeps driving non-zero values during blanking, which exposes any path that lets data leak past the gating. A frame where the source drops out for one active cycle, followed by a clean frame, checks the zeroed cycle and both the set and the clear of the sticky flag. A request held high through a whole frame checks that requests are ignored during a frame and that the blanking length is exact. A reset in the middle of a line checks the return to idle.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LINE,
        ST_LGAP,
        ST_FGAP
    } vtg_state_e;

    typedef struct packed {
        vtg_state_e st;
        logic       fv;
        logic       lv;
        logic       err;
    } vtg_reg_t;

endpackage

// File: rtl/vtg_span_timer.sv
module vtg_span_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/vtg_tap_gate.sv
module vtg_tap_gate #(
    parameter int PIX_W = 8
) (
    input  logic             en,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] pix_out
);
    always_comb begin
        pix_out = en ? pix_in : '0;
    end
endmodule

// File: rtl/dual_tap_vid_gen.sv
module dual_tap_vid_gen
    import vtg_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int LINES     = 3,
    parameter int PIX_CYC   = 640,
    parameter int LINE_GAP  = 20,
    parameter int FV_LEAD   = 5,
    parameter int FRAME_GAP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof_req,
    input  logic             src_valid,
    input  logic [PIX_W-1:0] src_pix0,
    input  logic [PIX_W-1:0] src_pix1,
    output logic             src_ready,
    output logic             fval,
    output logic             lval,
    output logic [PIX_W-1:0] tap0,
    output logic [PIX_W-1:0] tap1,
    output logic             underrun
);
    localparam int TAPS   = 2;
    localparam int MAX_A  = (PIX_CYC > LINE_GAP) ? PIX_CYC : LINE_GAP;
    localparam int MAX_B  = (FV_LEAD > FRAME_GAP) ? FV_LEAD : FRAME_GAP;
    localparam int PH_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int LN_W   = $clog2(LINES + 1);

    vtg_reg_t r_d, r_q;

    logic            ph_load, ph_last;
    logic [PH_W-1:0] ph_val;
    logic            ln_load, ln_step, ln_last;
    logic            pix_take;

    // phase length timer: lead-in, active line, line gap, frame blanking
    vtg_span_timer #(.CNT_W(PH_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_load),
        .step     (1'b1),
        .load_val (ph_val),
        .last     (ph_last)
    );

    // remaining-lines counter, stepped at the end of each non-final line
    vtg_span_timer #(.CNT_W(LN_W)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .load     (ln_load),
        .step     (ln_step),
        .load_val (LN_W'(LINES - 1)),
        .last     (ln_last)
    );

    always_comb begin
        r_d     = r_q;
        ph_load = 1'b0;
        ph_val  = '0;
        ln_load = 1'b0;
        ln_step = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sof_req) begin
                    r_d.st  = ST_LEAD;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(FV_LEAD - 1);
                    ln_load = 1'b1;
                end
            end
            ST_LEAD: begin
                if (ph_last) begin
                    r_d.st  = ST_LINE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(PIX_CYC - 1);
                end
            end
            ST_LINE: begin
                if (ph_last) begin
                    ph_load = 1'b1;
                    if (ln_last) begin
                        r_d.st = ST_FGAP;
                        ph_val = PH_W'(FRAME_GAP - 1);
                    end else begin
                        r_d.st  = ST_LGAP;
                        ph_val  = PH_W'(LINE_GAP - 1);
                        ln_step = 1'b1;
                    end
                end
            end
            ST_LGAP: begin
                if (ph_last) begin
                    r_d.st  = ST_LINE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(PIX_CYC - 1);
                end
            end
            ST_FGAP: begin
                if (ph_last) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (r_q.lv && !src_valid) begin
            r_d.err = 1'b1;
        end
        if ((r_q.st == ST_IDLE) && sof_req) begin
            r_d.err = 1'b0;
        end

        r_d.fv = (r_d.st == ST_LEAD) || (r_d.st == ST_LINE) || (r_d.st == ST_LGAP);
        r_d.lv = (r_d.st == ST_LINE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pix_take = r_q.lv && src_valid;

    logic [PIX_W-1:0] tap_in  [TAPS];
    logic [PIX_W-1:0] tap_out [TAPS];

    assign tap_in[0] = src_pix0;
    assign tap_in[1] = src_pix1;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        vtg_tap_gate #(.PIX_W(PIX_W)) u_gate (
            .en      (pix_take),
            .pix_in  (tap_in[g]),
            .pix_out (tap_out[g])
        );
    end

    assign tap0      = tap_out[0];
    assign tap1      = tap_out[1];
    assign src_ready = r_q.lv;
    assign fval      = r_q.fv;
    assign lval      = r_q.lv;
    assign underrun  = r_q.err;
endmodule

// File: rtl/vtg_chk.sv
module vtg_chk #(
    parameter int PIX_W   = 8,
    parameter int PIX_CYC = 640
) (
    input logic             clk,
    input logic             rst,
    input logic             sof_req,
    input logic             src_valid,
    input logic             fval,
    input logic             lval,
    input logic [PIX_W-1:0] tap0,
    input logic [PIX_W-1:0] tap1,
    input logic             underrun
);
    localparam int RUN_W = $clog2(PIX_CYC + 2);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (lval) run_q <= (run_q == RUN_W'(PIX_CYC)) ? run_q : run_q + 1'b1;
        else           run_q <= '0;
    end

    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(fval) |-> $past(sof_req)); // R2

    AST_LEAD_NOT_LINE: assert property (@(posedge clk) disable iff (rst)
        $rose(fval) |-> !lval); // R2

    AST_LINE_LEN: assert property (@(posedge clk) disable iff (rst)
        lval |-> (run_q < RUN_W'(PIX_CYC))); // R3

    AST_LV_IN_FV: assert property (@(posedge clk) disable iff (rst)
        lval |-> fval); // R5

    AST_FV_FALL_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
        $fell(fval) |-> $past(lval)); // R5

    AST_GAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lval |-> ((tap0 == '0) && (tap1 == '0))); // R8

    AST_STARVE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (lval && !src_valid) |=> underrun); // R9

    AST_STARVE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (lval && !src_valid) |-> ((tap0 == '0) && (tap1 == '0))); // R9
endmodule

bind dual_tap_vid_gen vtg_chk #(.PIX_W(PIX_W), .PIX_CYC(PIX_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sof_req   (sof_req),
    .src_valid (src_valid),
    .fval      (fval),
    .lval      (lval),
    .tap0      (tap0),
    .tap1      (tap1),
    .underrun  (underrun)
);

// File: tb/sim_dual_tap_vid_gen.sv
`timescale 1ns/1ps
module sim_dual_tap_vid_gen;
    localparam int PIX_W  = 8;
    localparam int NLINES = 3;
    localparam int ACT    = 640;
    localparam int LGAP   = 20;
    localparam int LEAD   = 5;
    localparam int FGAP   = 8;
    localparam int ENDT   = LEAD + NLINES * ACT + (NLINES - 1) * LGAP;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sof_req = 1'b0;
    logic             src_valid = 1'b0;
    logic [PIX_W-1:0] src_pix0 = '0;
    logic [PIX_W-1:0] src_pix1 = '0;
    logic             src_ready, fval, lval, underrun;
    logic [PIX_W-1:0] tap0, tap1;

    int n_vec  = 0;
    int n_fail = 0;
    logic exp_err = 1'b0;

    always #2.5 clk = ~clk;

    dual_tap_vid_gen #(
        .PIX_W(PIX_W), .LINES(NLINES), .PIX_CYC(ACT),
        .LINE_GAP(LGAP), .FV_LEAD(LEAD), .FRAME_GAP(FGAP)
    ) u0 (
        .clk(clk), .rst(rst), .sof_req(sof_req), .src_valid(src_valid),
        .src_pix0(src_pix0), .src_pix1(src_pix1), .src_ready(src_ready),
        .fval(fval), .lval(lval), .tap0(tap0), .tap1(tap1), .underrun(underrun)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic bit m_fv(input int t);
        return (t >= 0) && (t < ENDT);
    endfunction

    function automatic bit m_lv(input int t);
        int u;
        if (t < LEAD || t >= ENDT) return 1'b0;
        u = t - LEAD;
        return (u % (ACT + LGAP)) < ACT;
    endfunction

    function automatic int m_line(input int t);
        return (t - LEAD) / (ACT + LGAP);
    endfunction

    function automatic int m_col(input int t);
        return (t - LEAD) % (ACT + LGAP);
    endfunction

    task automatic chk_quiet(input string req);
        chk(req, "fval", int'(fval), 0);
        chk(req, "lval", int'(lval), 0);
        chk(req, "src_ready", int'(src_ready), 0);
        chk(req, "tap0", int'(tap0), 0);
        chk(req, "tap1", int'(tap1), 0);
    endtask

    // one frame; starve_t < 0 means no dropout; hold keeps sof_req high throughout
    task automatic run_frame(input int starve_t, input bit hold);
        bit lv_e;
        bit vld;
        logic [PIX_W-1:0] p0, p1;
        @(negedge clk);
        sof_req = 1'b1;
        src_valid = 1'b1;
        src_pix0 = 8'hA5;
        src_pix1 = 8'h5A;
        #1;
        chk_quiet("R1");
        chk("R9", "underrun before start", int'(underrun), int'(exp_err));
        for (int t = 0; t < ENDT + FGAP + 2; t++) begin
            @(negedge clk);
            sof_req = hold || (t == 100) || (t == ENDT + 2);
            lv_e = m_lv(t);
            vld  = (t != starve_t);
            if (lv_e) begin
                p0 = 8'(m_line(t) * 53 + 2 * m_col(t));
                p1 = 8'(m_line(t) * 53 + 2 * m_col(t) + 1);
            end else begin
                p0 = 8'hA5;
                p1 = 8'h5A;
            end
            src_valid = vld;
            src_pix0  = p0;
            src_pix1  = p1;
            if (t == 0) exp_err = 1'b0;
            if (hold && t == ENDT + FGAP + 1) exp_err = 1'b0;
            #1;
            if (t == ENDT + FGAP + 1) begin
                chk("R6", "fval restart", int'(fval), hold ? 1 : 0);
            end else if (t < LEAD) begin
                chk("R2", "fval lead", int'(fval), 1);
                chk("R2", "lval lead", int'(lval), 0);
            end else if (t >= ENDT) begin
                chk(t == ENDT ? "R5" : "R6", "fval blank", int'(fval), 0);
                chk("R6", "lval blank", int'(lval), 0);
            end else begin
                chk(lv_e ? "R3" : "R4", "fval", int'(fval), 1);
                chk(lv_e ? "R3" : "R4", "lval", int'(lval), int'(lv_e));
            end
            if (t <= ENDT + FGAP) begin
                chk("R3", "src_ready", int'(src_ready), int'(lv_e));
                if (lv_e && vld) begin
                    chk("R7", "tap0", int'(tap0), int'(p0));
                    chk("R7", "tap1", int'(tap1), int'(p1));
                end else if (lv_e) begin
                    chk("R9", "tap0 starved", int'(tap0), 0);
                    chk("R9", "tap1 starved", int'(tap1), 0);
                end else begin
                    chk("R8", "tap0 gap", int'(tap0), 0);
                    chk("R8", "tap1 gap", int'(tap1), 0);
                end
            end
            chk("R9", "underrun", int'(underrun), int'(exp_err));
            if (lv_e && !vld) exp_err = 1'b1;
        end
        @(negedge clk);
        sof_req = 1'b0;
        src_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sof_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_err = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk_quiet("R1");
        chk("R1", "underrun", int'(underrun), 0);
        repeat (5) @(negedge clk);
        #1;
        chk_quiet("R1");
    endtask

    task automatic t_clean_frame();
        run_frame(-1, 1'b0);
    endtask

    task automatic t_starved_frame();
        run_frame(LEAD + ACT + LGAP + 17, 1'b0);
        run_frame(-1, 1'b0);
    endtask

    task automatic t_held_request();
        run_frame(-1, 1'b1);
        do_reset();
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        sof_req = 1'b1;
        src_valid = 1'b1;
        src_pix0 = 8'h11;
        src_pix1 = 8'h22;
        @(negedge clk);
        sof_req = 1'b0;
        repeat (300) @(negedge clk);
        #1;
        chk("R10", "lval before reset", int'(lval), 1);
        @(negedge clk);
        src_valid = 1'b0;
        @(negedge clk);
        src_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk_quiet("R10");
        chk("R10", "underrun", int'(underrun), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk_quiet("R10");
    endtask

    initial begin
        t_reset_state();
        t_clean_frame();
        t_starved_frame();
        t_held_request();
        t_mid_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule